// File: doc/BRIEF.md
# Nested Vectored Interrupt Arbiter

This block picks which exception a processor core should take next. It watches 64 peripheral request lines and three system sources: the boot entry, a non-maskable request and a hard-fault request. It also holds a software-raised service request. Each peripheral line has an enable bit, a pending bit and a 2-bit programmable priority. The boot entry, the non-maskable request and the hard fault outrank every programmable level. A smaller priority value is more urgent. The block presents the most urgent pending and enabled exception as an exception number together with its vector address.

The core acknowledges the presented exception. This marks it active, clears its pending bit and puts the block in handler mode. A return pulse retires the most urgent active exception. A newly presented exception may preempt only when it is strictly more urgent than every active one. A word-addressed register port holds the enables, priorities and control bits. That port also provides a global mask and the software pend request. Saving processor state on entry is left to the core.

Top module: `nest_irq_arb`

## Requirements
- R1: Peripheral line k has exception number 16+k. The presented vector address always equals the exception number times 4.
- R2: The fixed sources rank in this order, most urgent first: boot entry (number 1), non-maskable (number 2), hard fault (number 3). All three rank ahead of every programmable level. A programmable field value p ranks at p, where 0 is the most urgent.
- R3: When pending candidates share a level, the lower exception number is presented.
- R4: Enable words start at word 0 (write 1 to set) and word 2 (write 1 to clear). Line k sits at bit k%32 of word k/32 within each pair. Writing 0 has no effect. Reading either word returns the current enables. A disabled line is never presented, but it stays pending.
- R5: Priority words occupy words 4 to 19. Line k uses byte k%4 of word 4+k/4, and its 2-bit field is held in bits 7:6 of that byte. The fields read back as written.
- R6: The control word is word 20. While its bit 0 (global mask) is 1, only the non-maskable request can be presented.
- R7: Writing 1 to bit 1 of the control word pends service exception 14. Bits 15:14 hold its priority, which resets to 3. Bit 1 reads back as the pending state. Exception 14 is presented only while no exception is active.
- R8: A pending bit is set by a rising edge on its request input. A level held high does not set it again. The bit clears on acknowledge. A new edge that arrives during service leaves the exception pending again.
- R9: An acknowledge while an exception is presented makes that exception active and enters handler mode. A return retires the most urgent active exception. Handler mode ends when the last active exception retires.
- R10: A pending exception whose level is equal to or less urgent than the most urgent active level is held off until that exception retires.
- R11: After reset, all lines are disabled, all priorities are 0, the mask is off, the mode is thread, and the boot entry (number 1, vector 4) is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 64 | Peripheral request lines, edge-sensed |
| nmi_in | input | 1 | Non-maskable request, edge-sensed |
| fault_in | input | 1 | Hard-fault request, edge-sensed |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_ack | input | 1 | Core takes the presented exception |
| irq_ret | input | 1 | Core returns from the current exception |
| irq_valid | output | 1 | An exception is presented |
| irq_num | output | 7 | Presented exception number |
| irq_vector | output | 9 | Presented vector address |
| handler_mode | output | 1 | High while any exception is active |

## Verification
The hardest state to reach from the ports is a nested stack of active exceptions. In that state, a newly arriving request at exactly the running level has to be held off. Then, after a return, it has to be released, because the next active level down is less urgent. The bench reaches this state by programming three lines to different levels, taking the least urgent line and then a more urgent one, and then raising a third line at the same level as the running one. The software service request is pended while a handler runs. The bench checks that this request appears only after the last return. It also checks that re-pending by an edge during service happens, and that a held level does not re-pend.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;
    localparam int EXC_BOOT   = 1;
    localparam int EXC_NMI    = 2;
    localparam int EXC_FAULT  = 3;
    localparam int EXC_SVC    = 14;
    localparam int EXC_LINE0  = 16;
    localparam int FIXED_LVLS = 3;
endpackage

// File: rtl/nest_irq_pick.sv
module nest_irq_pick #(
    parameter int N  = 80,
    parameter int LW = 4,
    parameter int NW = 7
) (
    input  logic [N-1:0]         req,
    input  logic [N-1:0][LW-1:0] lvl,
    output logic                 found,
    output logic [NW-1:0]        idx,
    output logic [LW-1:0]        best
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '1;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!found || lvl[i] < best)) begin
                found = 1'b1;
                idx   = NW'(i);
                best  = lvl[i];
            end
        end
    end
endmodule

// File: rtl/nest_irq_edge.sv
module nest_irq_edge #(
    parameter int W = 66
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_in,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_in;
        rise   = lvl_in & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/nest_irq_arb.sv
module nest_irq_arb
    import nest_irq_pkg::*;
#(
    parameter int NUM_IRQ   = 64,
    parameter int PRIO_BITS = 2,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_IRQ-1:0]   irq_in,
    input  logic                 nmi_in,
    input  logic                 fault_in,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 irq_ack,
    input  logic                 irq_ret,
    output logic                 irq_valid,
    output logic [$clog2(NUM_IRQ+EXC_LINE0)-1:0]   irq_num,
    output logic [$clog2(NUM_IRQ+EXC_LINE0)+1:0]   irq_vector,
    output logic                 handler_mode
);
    localparam int NUM_EXC   = NUM_IRQ + EXC_LINE0;
    localparam int NW        = $clog2(NUM_EXC);
    localparam int LW        = PRIO_BITS + 2;
    localparam int EN_WORDS  = (NUM_IRQ + 31) / 32;
    localparam int PR_WORDS  = (NUM_IRQ + 3) / 4;
    localparam int SET_BASE  = 0;
    localparam int CLR_BASE  = EN_WORDS;
    localparam int PRI_BASE  = 2 * EN_WORDS;
    localparam int CTRL_ADDR = PRI_BASE + PR_WORDS;
    localparam int FLD_LO    = 8 - PRIO_BITS;
    localparam int SVC_LO    = 16 - PRIO_BITS;

    typedef struct packed {
        logic [NUM_IRQ-1:0]                en;
        logic [NUM_EXC-1:0]                pend;
        logic [NUM_EXC-1:0]                act;
        logic [NUM_IRQ-1:0][PRIO_BITS-1:0] pri;
        logic [PRIO_BITS-1:0]              svc_pri;
        logic                              mask;
        logic                              hmode;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_IRQ+1:0]          rise;
    logic [NUM_EXC-1:0]          cand;
    logic [NUM_EXC-1:0][LW-1:0]  lvl;
    logic                        w_found, a_found;
    logic [NW-1:0]               w_num, a_num;
    logic [LW-1:0]               w_lvl, a_lvl, run_lvl;
    logic                        glob_mask;
    logic [NUM_EXC-1:0]          act_vec;

    nest_irq_edge #(.W(NUM_IRQ + 2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_in ({fault_in, nmi_in, irq_in}),
        .rise   (rise)
    );

    // level and candidacy per exception number
    always_comb begin
        lvl  = '1;
        cand = '0;
        lvl[EXC_BOOT]  = LW'(0);
        lvl[EXC_NMI]   = LW'(1);
        lvl[EXC_FAULT] = LW'(2);
        lvl[EXC_SVC]   = LW'(st_q.svc_pri) + LW'(FIXED_LVLS);
        cand[EXC_BOOT]  = st_q.pend[EXC_BOOT] && !st_q.mask;
        cand[EXC_NMI]   = st_q.pend[EXC_NMI];
        cand[EXC_FAULT] = st_q.pend[EXC_FAULT] && !st_q.mask;
        cand[EXC_SVC]   = st_q.pend[EXC_SVC] && !st_q.mask && (st_q.act == '0);
        for (int k = 0; k < NUM_IRQ; k++) begin
            lvl[EXC_LINE0+k]  = LW'(st_q.pri[k]) + LW'(FIXED_LVLS);
            cand[EXC_LINE0+k] = st_q.pend[EXC_LINE0+k] && st_q.en[k] && !st_q.mask;
        end
    end

    nest_irq_pick #(.N(NUM_EXC), .LW(LW), .NW(NW)) u_pick_pend (
        .req   (cand),
        .lvl   (lvl),
        .found (w_found),
        .idx   (w_num),
        .best  (w_lvl)
    );

    nest_irq_pick #(.N(NUM_EXC), .LW(LW), .NW(NW)) u_pick_act (
        .req   (st_q.act),
        .lvl   (lvl),
        .found (a_found),
        .idx   (a_num),
        .best  (a_lvl)
    );

    always_comb begin
        run_lvl      = a_found ? a_lvl : '1;
        irq_valid    = w_found && (w_lvl < run_lvl);
        irq_num      = w_num;
        irq_vector   = {w_num, 2'b00};
        handler_mode = st_q.hmode;
        glob_mask    = st_q.mask;
        act_vec      = st_q.act;
    end

    // register read mux
    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < NUM_IRQ; k++) begin
            if (int'(reg_addr) == SET_BASE + k / 32 || int'(reg_addr) == CLR_BASE + k / 32)
                reg_rdata[k % 32] = st_q.en[k];
            if (int'(reg_addr) == PRI_BASE + k / 4)
                reg_rdata[(k % 4) * 8 + FLD_LO +: PRIO_BITS] = st_q.pri[k];
        end
        if (int'(reg_addr) == CTRL_ADDR) begin
            reg_rdata[0]                  = st_q.mask;
            reg_rdata[1]                  = st_q.pend[EXC_SVC];
            reg_rdata[SVC_LO +: PRIO_BITS] = st_q.svc_pri;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (reg_we) begin
            for (int k = 0; k < NUM_IRQ; k++) begin
                if (int'(reg_addr) == SET_BASE + k / 32 && reg_wdata[k % 32])
                    st_d.en[k] = 1'b1;
                if (int'(reg_addr) == CLR_BASE + k / 32 && reg_wdata[k % 32])
                    st_d.en[k] = 1'b0;
                if (int'(reg_addr) == PRI_BASE + k / 4)
                    st_d.pri[k] = reg_wdata[(k % 4) * 8 + FLD_LO +: PRIO_BITS];
            end
            if (int'(reg_addr) == CTRL_ADDR) begin
                st_d.mask    = reg_wdata[0];
                st_d.svc_pri = reg_wdata[SVC_LO +: PRIO_BITS];
                if (reg_wdata[1]) st_d.pend[EXC_SVC] = 1'b1;
            end
        end
        if (irq_ret && a_found)
            st_d.act[a_num] = 1'b0;
        if (irq_ack && irq_valid) begin
            st_d.act[w_num]  = 1'b1;
            st_d.pend[w_num] = 1'b0;
            st_d.hmode       = 1'b1;
        end else if (irq_ret && a_found && st_d.act == '0) begin
            st_d.hmode = 1'b0;
        end
        for (int k = 0; k < NUM_IRQ; k++)
            if (rise[k]) st_d.pend[EXC_LINE0+k] = 1'b1;
        if (rise[NUM_IRQ])   st_d.pend[EXC_NMI]   = 1'b1;
        if (rise[NUM_IRQ+1]) st_d.pend[EXC_FAULT] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q                <= '0;
            st_q.pend[EXC_BOOT] <= 1'b1;
            st_q.svc_pri        <= '1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/nest_irq_arb_chk.sv
module nest_irq_arb_chk #(
    parameter int NUM_EXC = 80,
    parameter int NW      = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq_valid,
    input logic [NW-1:0]      irq_num,
    input logic               irq_ack,
    input logic               handler_mode,
    input logic               glob_mask,
    input logic [NUM_EXC-1:0] act_vec
);
    p_ack_enters_handler_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack && irq_valid |=> handler_mode);

    p_ack_marks_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack && irq_valid |=> act_vec[$past(irq_num)]);

    p_mode_tracks_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        handler_mode == (act_vec != '0));

    p_mask_nmi_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        glob_mask && irq_valid |-> irq_num == NW'(2));

    p_svc_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid && irq_num == NW'(14) |-> act_vec == '0);
endmodule

bind nest_irq_arb nest_irq_arb_chk #(.NUM_EXC(NUM_EXC), .NW(NW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_valid    (irq_valid),
    .irq_num      (irq_num),
    .irq_ack      (irq_ack),
    .handler_mode (handler_mode),
    .glob_mask    (glob_mask),
    .act_vec      (act_vec)
);

// File: tb/nest_irq_arb_bench.sv
`timescale 1ns/1ps
module nest_irq_arb_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_in = '0;
    logic        nmi_in = 1'b0, fault_in = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        irq_ack = 1'b0, irq_ret = 1'b0;
    logic        irq_valid, handler_mode;
    logic [6:0]  irq_num;
    logic [8:0]  irq_vector;
    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    nest_irq_arb u_nest_irq_arb (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .nmi_in(nmi_in), .fault_in(fault_in),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_valid(irq_valid), .irq_num(irq_num),
        .irq_vector(irq_vector), .handler_mode(handler_mode)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk); reg_we = 1'b1; reg_addr = 8'(a); reg_wdata = 32'(d);
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk); reg_addr = 8'(a); #1 d = int'(reg_rdata);
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic ret();
        @(negedge clk); irq_ret = 1'b1; @(negedge clk); irq_ret = 1'b0;
    endtask

    task automatic pulse(input int k);
        @(negedge clk); irq_in[k] = 1'b1; @(negedge clk); irq_in[k] = 1'b0;
    endtask

    task automatic see(input string req, input int v, input int num);
        chk({req, " valid"}, int'(irq_valid), v);
        if (v != 0) begin
            chk({req, " num"}, int'(irq_num), num);
            chk({req, " vector"}, int'(irq_vector), num * 4);
        end
    endtask

    task automatic t_reset();
        int d;
        see("R11 boot pending", 1, 1);
        chk("R11 thread mode", int'(handler_mode), 0);
        rd(0, d);  chk("R11 enables clear", d, 0);
        rd(4, d);  chk("R11 priorities zero", d, 0);
        rd(20, d); chk("R11 control reset", d, 32'hC000);
        ack();
        chk("R9 handler on ack", int'(handler_mode), 1);
        see("R9 nothing else", 0, 0);
        ret();
        chk("R9 thread after return", int'(handler_mode), 0);
    endtask

    task automatic t_enable();
        int d;
        wr(1, 32'h8);
        rd(1, d); chk("R4 set word reads", d, 8);
        rd(3, d); chk("R4 clear word reads", d, 8);
        rd(0, d); chk("R4 other word untouched", d, 0);
        pulse(35);
        see("R1 line 35", 1, 51);
        wr(3, 32'h8);
        see("R4 disabled hidden", 0, 0);
        rd(1, d); chk("R4 cleared", d, 0);
        wr(1, 32'h8);
        see("R4 still pending", 1, 51);
        ack(); ret();
        see("R8 cleared by ack", 0, 0);
        wr(3, 32'h8);
    endtask

    task automatic t_tie();
        int d;
        wr(0, 32'h20); wr(1, 32'h100);
        pulse(5); pulse(40);
        see("R3 tie lower number", 1, 21);
        wr(5, 32'h4000);
        rd(5, d); chk("R5 field readback", d, 32'h4000);
        see("R5 priority reorders", 1, 56);
        ack();
        see("R10 less urgent held", 0, 0);
        ret();
        see("R10 released", 1, 21);
        ack(); ret();
        chk("R9 thread", int'(handler_mode), 0);
    endtask

    task automatic t_fixed();
        wr(0, 32'h21);
        pulse(0);
        @(negedge clk); nmi_in = 1'b1; fault_in = 1'b1;
        @(negedge clk); nmi_in = 1'b0; fault_in = 1'b0;
        see("R2 nmi first", 1, 2);
        ack();
        see("R2 fault waits", 0, 0);
        ret();
        see("R2 fault next", 1, 3);
        ack(); ret();
        see("R2 line last", 1, 16);
        ack(); ret();
    endtask

    task automatic t_mask();
        pulse(0);
        wr(20, 32'hC001);
        see("R6 line masked", 0, 0);
        @(negedge clk); fault_in = 1'b1; @(negedge clk); fault_in = 1'b0;
        see("R6 fault masked", 0, 0);
        @(negedge clk); nmi_in = 1'b1; @(negedge clk); nmi_in = 1'b0;
        see("R6 nmi passes", 1, 2);
        ack(); ret();
        see("R6 rest masked", 0, 0);
        wr(20, 32'hC000);
        see("R6 unmask fault", 1, 3);
        ack(); ret();
        see("R6 unmask line", 1, 16);
        ack(); ret();
    endtask

    task automatic t_preempt();
        wr(4, 32'h80); wr(14, 32'h40);
        pulse(0);
        see("R10 base", 1, 16);
        ack();
        pulse(40);
        see("R10 preempt", 1, 56);
        ack();
        pulse(5);
        see("R10 equal held", 0, 0);
        ret();
        see("R10 after return", 1, 21);
        ack(); ret();
        chk("R9 still nested", int'(handler_mode), 1);
        ret();
        chk("R9 last return", int'(handler_mode), 0);
        see("R9 idle", 0, 0);
    endtask

    task automatic t_svc();
        int d;
        pulse(0); ack();
        wr(20, 32'hC002);
        rd(20, d); chk("R7 pend readback", d, 32'hC002);
        see("R7 waits for idle", 0, 0);
        ret();
        see("R7 taken when idle", 1, 14);
        ack();
        rd(20, d); chk("R7 pend cleared", d, 32'hC000);
        ret();
    endtask

    task automatic t_edge();
        @(negedge clk); irq_in[0] = 1'b1;
        @(negedge clk);
        see("R8 edge pends", 1, 16);
        ack(); ret();
        see("R8 held level no repend", 0, 0);
        @(negedge clk); irq_in[0] = 1'b0;
        pulse(0); ack();
        pulse(0);
        see("R8 repend held off", 0, 0);
        ret();
        see("R8 repend during service", 1, 16);
        ack(); ret();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_tie();
        t_fixed();
        t_mask();
        t_preempt();
        t_svc();
        t_edge();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule